// File: doc/BRIEF.md
# Watchdog Timer with Reset Generator

This block is an up-counting watchdog. Software reloads it often enough that it never wraps. A prescaler feeds the 8-bit counter with one tick every 2 to 4096 clocks, picked by a 3-bit clock-select field. The counter runs only while the control register has both its watchdog-mode bit and its run bit set.

When the counter wraps from all ones to zero, the block does the following:
- It raises an external overflow pin for 128 clocks.
- It sets a sticky overflow flag.
- If resets are enabled, it starts a 512-clock internal reset. The reset starts in the same cycle as the pin and comes out either as a power-on reset or as a manual reset, as software chooses.

The internal reset clears the counter and the control register and holds them cleared. The reset-control register keeps its contents through it. The external power-on input clears everything. The external manual-reset input leaves the counter and the control register alone. If that input is asserted in the cycle of an overflow, it takes priority: the internal reset is suppressed and the overflow flag is cleared.

All three registers are written through one 16-bit port. The upper byte must carry a key, or the write is dropped.

Top module: `wdog_rst_gen`

## Requirements
- R1: The counter advances only while control-register bit 6 (watchdog mode) and bit 5 (run) are both 1. With either bit at 0, it holds its value.
- R2: Clock-select field bits 2:0 value k sets a tick period of 2^s clocks, with s taken from {1,3,5,6,8,9,11,12} for k = 0..7. The first increment lands exactly one period after the write that starts the counter, counted from a stopped state.
- R3: When a tick arrives with the counter at 0xFF, the counter wraps to 0. The overflow output goes high in the next cycle for exactly 128 cycles, and reset-control bit 7 (overflow flag) becomes 1.
- R4: With reset-control bit 6 (reset enable) at 1, an internal reset output rises in the same cycle as the overflow output and stays high for exactly 512 cycles.
- R5: Reset-control bit 5 picks the reset type: 0 drives the internal power-on output, 1 drives the internal manual-reset output. Only the selected output is driven.
- R6: If the active-low manual-reset input is low in the cycle of an overflow, no internal reset starts and the overflow flag reads 0. The overflow pulse still occurs.
- R7: The reset-control register keeps its contents through an internal reset of either type. Only the external power-on input clears it.
- R8: An internal reset clears the counter and the control register and keeps them at zero. The external manual-reset input and an overflow without reset enable leave both unchanged.
- R9: The overflow flag stays 1 until a keyed write to the reset-control register carries 0 in bit 7. Writing 1 there never sets it.
- R10: A write reaches a register only when data bits 15:8 equal 0x5A. Select 0 addresses the counter, 1 the control register, 2 the reset-control register, and select 3 reaches none of them.
- R11: A keyed counter write loads data bits 7:0 into the counter.
- R12: An overflow that occurs while the overflow pulse is high does not lengthen or restart it.
- R13: While the active-low power-on input is low, all registers read 0 and all three pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | External power-on reset, active low, synchronous |
| mresN | input | 1 | External manual reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 counter, 1 control, 2 reset control, 3 none |
| wrData | input | 16 | Key in bits 15:8, value in bits 7:0 |
| cntOut | output | 8 | Counter value |
| csrOut | output | 8 | Control register: bit 6 mode, bit 5 run, bits 2:0 clock select |
| rcsrOut | output | 8 | Reset control: bit 7 flag, bit 6 reset enable, bit 5 reset type |
| ovfOut | output | 1 | External overflow pulse |
| intPorOut | output | 1 | Internal power-on reset pulse |
| intMresOut | output | 1 | Internal manual reset pulse |

## Verification
A wrong prescaler terminal count shows as a first increment that comes early or late. The sweep measures that distance for every clock-select value, so a wrong count is caught on its first period.

A pulse counter that loads the wrong length, or that reloads when a second overflow arrives, changes the measured high time of the pin. A reset counter with the same fault changes the measured width of the reset output. Either error shows within one pulse.

A register cleared by the wrong reset source shows at the next readback after that reset. This covers a reset-control register cleared by an internal reset, and a control register cleared by the manual-reset pin.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [1:0] SEL_CNT  = 2'd0;
  localparam logic [1:0] SEL_CSR  = 2'd1;
  localparam logic [1:0] SEL_RCSR = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;      // prescaled count enable
    logic wrCnt;     // keyed counter write
    logic wrCsr;     // keyed control write
    logic wrRcsr;    // keyed reset-control write
    logic ovf;       // counter wraps this cycle
    logic extWins;   // manual-reset pin asserted this cycle
    logic initRegs;  // internal reset active: hold counter/control cleared
  } wdStrobe_t;

  // log2 of the prescaler period for each clock-select value
  function automatic logic [3:0] divShift(input logic [2:0] sel);
    case (sel)
      3'd0: return 4'd1;
      3'd1: return 4'd3;
      3'd2: return 4'd5;
      3'd3: return 4'd6;
      3'd4: return 4'd8;
      3'd5: return 4'd9;
      3'd6: return 4'd11;
      default: return 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          PRESC_W    = 12,
  parameter int          OVF_CYCLES = 128,
  parameter int          RST_CYCLES = 512,
  parameter logic [7:0]  KEY        = 8'h5A
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       mresN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [7:0] wrKey,
  input  logic       wdActive,
  input  logic [2:0] clkSel,
  input  logic       rstEn,
  input  logic       rstSel,
  input  logic       cntAtMax,
  output wdStrobe_t  st,
  output logic       ovfOut,
  output logic       intPorOut,
  output logic       intMresOut
);

  localparam int OVF_W = $clog2(OVF_CYCLES + 1);
  localparam int RST_W = $clog2(RST_CYCLES + 1);

  logic [PRESC_W-1:0] prescQ;
  logic [PRESC_W:0]   divFull;
  logic [PRESC_W-1:0] divLast;
  logic               tick;
  logic               ovfEvt;
  logic               wrOk;
  logic               startRst;
  logic [OVF_W-1:0]   ovfCntQ;
  logic [RST_W-1:0]   rstCntQ;
  logic               rstTypeQ;
  logic               rstBusy;

  // Prescaler: cleared while stopped, wraps at the selected period
  assign divFull = (PRESC_W + 1)'(1) << divShift(clkSel);
  assign divLast = divFull[PRESC_W-1:0] - PRESC_W'(1);
  assign tick    = wdActive && (prescQ == divLast);

  always_ff @(posedge clk) begin
    if (!porN)          prescQ <= '0;
    else if (!wdActive) prescQ <= '0;
    else if (tick)      prescQ <= '0;
    else                prescQ <= prescQ + PRESC_W'(1);
  end

  assign ovfEvt   = tick && cntAtMax;
  assign wrOk     = wrEn && (wrKey == KEY);
  assign rstBusy  = (rstCntQ != '0);
  assign startRst = ovfEvt && rstEn && mresN && !rstBusy;

  // Overflow pin pulse timer: loads only from idle
  always_ff @(posedge clk) begin
    if (!porN)                          ovfCntQ <= '0;
    else if (ovfEvt && ovfCntQ == '0)   ovfCntQ <= OVF_W'(OVF_CYCLES);
    else if (ovfCntQ != '0)             ovfCntQ <= ovfCntQ - OVF_W'(1);
  end

  // Internal reset pulse timer with latched type
  always_ff @(posedge clk) begin
    if (!porN) begin
      rstCntQ  <= '0;
      rstTypeQ <= 1'b0;
    end else if (startRst) begin
      rstCntQ  <= RST_W'(RST_CYCLES);
      rstTypeQ <= rstSel;
    end else if (rstBusy) begin
      rstCntQ  <= rstCntQ - RST_W'(1);
    end
  end

  assign ovfOut     = (ovfCntQ != '0);
  assign intPorOut  = rstBusy && !rstTypeQ;
  assign intMresOut = rstBusy && rstTypeQ;

  always_comb begin
    st          = '0;
    st.tick     = tick;
    st.wrCnt    = wrOk && (wrSel == SEL_CNT);
    st.wrCsr    = wrOk && (wrSel == SEL_CSR);
    st.wrRcsr   = wrOk && (wrSel == SEL_RCSR);
    st.ovf      = ovfEvt;
    st.extWins  = !mresN;
    st.initRegs = rstBusy;
  end

  AST_OVF_LOAD: assert property (@(posedge clk) disable iff (!porN)
    (st.ovf && ovfCntQ == '0) |=> (ovfCntQ == OVF_W'(OVF_CYCLES))); // R3
  AST_OVF_NO_RESTART: assert property (@(posedge clk) disable iff (!porN)
    (ovfCntQ != '0) |=> (ovfCntQ == $past(ovfCntQ) - OVF_W'(1))); // R12
  AST_RST_WITH_OVF: assert property (@(posedge clk) disable iff (!porN)
    $rose(intPorOut || intMresOut) |-> $rose(ovfOut)); // R4
  AST_RST_TYPE: assert property (@(posedge clk) disable iff (!porN)
    $rose(intMresOut) |-> $past(rstSel)); // R5
  AST_EXT_BLOCKS_RST: assert property (@(posedge clk) disable iff (!porN)
    (!mresN && rstCntQ == '0) |=> (rstCntQ == '0)); // R6
  AST_INIT_STOPS: assert property (@(posedge clk) disable iff (!porN)
    (rstCntQ != '0) |=> !wdActive); // R8

endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             porN,
  input  wdStrobe_t        st,
  input  logic [7:0]       wrVal,
  output logic [CNT_W-1:0] cntQ,
  output logic [7:0]       csrOut,
  output logic [7:0]       rcsrOut,
  output logic             wdActive,
  output logic [2:0]       clkSel,
  output logic             rstEn,
  output logic             rstSel,
  output logic             cntAtMax
);

  localparam int CSR_MODE  = 6;
  localparam int CSR_RUN   = 5;
  localparam int RCSR_FLAG = 7;
  localparam int RCSR_EN   = 6;
  localparam int RCSR_TYPE = 5;

  logic       modeQ, runQ;
  logic [2:0] cksQ;
  logic       flagQ, rstEnQ, rstSelQ;

  always_ff @(posedge clk) begin
    if (!porN)            cntQ <= '0;
    else if (st.initRegs) cntQ <= '0;
    else if (st.wrCnt)    cntQ <= wrVal[CNT_W-1:0];
    else if (st.tick)     cntQ <= cntQ + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!porN || st.initRegs) begin
      modeQ <= 1'b0;
      runQ  <= 1'b0;
      cksQ  <= '0;
    end else if (st.wrCsr) begin
      modeQ <= wrVal[CSR_MODE];
      runQ  <= wrVal[CSR_RUN];
      cksQ  <= wrVal[2:0];
    end
  end

  // Reset-control register: only the power-on input clears it
  always_ff @(posedge clk) begin
    if (!porN) begin
      flagQ   <= 1'b0;
      rstEnQ  <= 1'b0;
      rstSelQ <= 1'b0;
    end else begin
      if (st.ovf)                               flagQ <= !st.extWins;
      else if (st.wrRcsr && !wrVal[RCSR_FLAG])  flagQ <= 1'b0;
      if (st.wrRcsr) begin
        rstEnQ  <= wrVal[RCSR_EN];
        rstSelQ <= wrVal[RCSR_TYPE];
      end
    end
  end

  always_comb begin
    csrOut            = '0;
    csrOut[CSR_MODE]  = modeQ;
    csrOut[CSR_RUN]   = runQ;
    csrOut[2:0]       = cksQ;
    rcsrOut           = '0;
    rcsrOut[RCSR_FLAG] = flagQ;
    rcsrOut[RCSR_EN]   = rstEnQ;
    rcsrOut[RCSR_TYPE] = rstSelQ;
  end

  assign wdActive = modeQ && runQ;
  assign clkSel   = cksQ;
  assign rstEn    = rstEnQ;
  assign rstSel   = rstSelQ;
  assign cntAtMax = &cntQ;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (!wdActive && !st.wrCnt && !st.initRegs) |=> $stable(cntQ)); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!porN)
    (flagQ && !st.ovf && !st.wrRcsr) |=> flagQ); // R9
  AST_RCSR_KEEP: assert property (@(posedge clk) disable iff (!porN)
    (st.initRegs && !st.wrRcsr) |=> $stable({rstEnQ, rstSelQ})); // R7

endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen
  import wdog_pkg::*;
#(
  parameter int         CNT_W      = 8,
  parameter int         PRESC_W    = 12,
  parameter int         OVF_CYCLES = 128,
  parameter int         RST_CYCLES = 512,
  parameter logic [7:0] KEY        = 8'h5A
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             mresN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [15:0]      wrData,
  output logic [CNT_W-1:0] cntOut,
  output logic [7:0]       csrOut,
  output logic [7:0]       rcsrOut,
  output logic             ovfOut,
  output logic             intPorOut,
  output logic             intMresOut
);

  wdStrobe_t  st;
  logic       wdActive;
  logic [2:0] clkSel;
  logic       rstEn;
  logic       rstSel;
  logic       cntAtMax;

  wdog_ctrl #(
    .PRESC_W    (PRESC_W),
    .OVF_CYCLES (OVF_CYCLES),
    .RST_CYCLES (RST_CYCLES),
    .KEY        (KEY)
  ) u_ctrl (
    .clk        (clk),
    .porN       (porN),
    .mresN      (mresN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrKey      (wrData[15:8]),
    .wdActive   (wdActive),
    .clkSel     (clkSel),
    .rstEn      (rstEn),
    .rstSel     (rstSel),
    .cntAtMax   (cntAtMax),
    .st         (st),
    .ovfOut     (ovfOut),
    .intPorOut  (intPorOut),
    .intMresOut (intMresOut)
  );

  wdog_dp #(
    .CNT_W (CNT_W)
  ) u_dp (
    .clk      (clk),
    .porN     (porN),
    .st       (st),
    .wrVal    (wrData[7:0]),
    .cntQ     (cntOut),
    .csrOut   (csrOut),
    .rcsrOut  (rcsrOut),
    .wdActive (wdActive),
    .clkSel   (clkSel),
    .rstEn    (rstEn),
    .rstSel   (rstSel),
    .cntAtMax (cntAtMax)
  );

endmodule

// File: tb/wdog_rst_gen_bench.sv
module wdog_rst_gen_bench;

  localparam logic [7:0] KEY  = 8'h5A;
  localparam logic [1:0] SCNT = 2'd0;
  localparam logic [1:0] SCSR = 2'd1;
  localparam logic [1:0] SRC  = 2'd2;

  logic        clk = 1'b0;
  logic        porN, mresN, wrEn;
  logic [1:0]  wrSel;
  logic [15:0] wrData;
  logic [7:0]  cntOut, csrOut, rcsrOut;
  logic        ovfOut, intPorOut, intMresOut;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  wdog_rst_gen u_wdog_rst_gen (
    .clk(clk), .porN(porN), .mresN(mresN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .cntOut(cntOut), .csrOut(csrOut), .rcsrOut(rcsrOut),
    .ovfOut(ovfOut), .intPorOut(intPorOut), .intMresOut(intMresOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] key, input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = {key, val};
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic arm(input logic [7:0] csrVal, input logic [7:0] preload);
    wr(SCSR, KEY, 8'h00);
    wr(SCNT, KEY, preload);
    wr(SCSR, KEY, csrVal);
  endtask

  task automatic waitOvf();
    for (int g = 0; g < 5000; g++) begin
      if (ovfOut) break;
      @(negedge clk);
    end
  endtask

  task automatic watch(input int span, output int ovfHi, output int porHi, output int mresHi,
                       output int porRise, output int mresRise);
    ovfHi = 0; porHi = 0; mresHi = 0;
    waitOvf();
    porRise = int'(intPorOut);
    mresRise = int'(intMresOut);
    for (int i = 0; i < span; i++) begin
      ovfHi += int'(ovfOut);
      porHi += int'(intPorOut);
      mresHi += int'(intMresOut);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int oh, ph, mh, pr, mr, n;
    int shTab[8] = '{1, 3, 5, 6, 8, 9, 11, 12};
    porN = 1'b0; mresN = 1'b1; wrEn = 1'b0; wrSel = '0; wrData = '0;
    repeat (5) @(negedge clk);
    // R13 reset state
    check("R13", "cnt", cntOut, 0);
    check("R13", "csr", csrOut, 0);
    check("R13", "rcsr", rcsrOut, 0);
    check("R13", "pulses", {ovfOut, intPorOut, intMresOut}, 0);
    porN = 1'b1;
    repeat (2) @(negedge clk);

    // R10 key protection and select 3
    wr(SCNT, 8'h12, 8'h44); check("R10", "bad key cnt", cntOut, 0);
    wr(SCSR, 8'hA5, 8'h61); check("R10", "bad key csr", csrOut, 0);
    wr(SRC, 8'h00, 8'h40);  check("R10", "bad key rcsr", rcsrOut, 0);
    wr(SCNT, KEY, 8'h44);   check("R11", "reload", cntOut, 8'h44);
    wr(2'd3, KEY, 8'h7F);
    check("R10", "sel3 cnt", cntOut, 8'h44);
    check("R10", "sel3 csr", csrOut, 0);
    check("R10", "sel3 rcsr", rcsrOut, 0);

    // R1 both bits needed
    wr(SCNT, KEY, 8'h10);
    wr(SCSR, KEY, 8'h40); repeat (20) @(negedge clk);
    check("R1", "mode only", cntOut, 8'h10);
    check("R10", "csr mode field", csrOut, 8'h40);
    wr(SCSR, KEY, 8'h20); repeat (20) @(negedge clk);
    check("R1", "run only", cntOut, 8'h10);

    // R2 prescaler sweep over every clock select
    for (int c = 0; c < 8; c++) begin
      wr(SCSR, KEY, 8'h00);
      wr(SCNT, KEY, 8'h20);
      wr(SCSR, KEY, 8'(8'h60 | c));
      check("R10", "csr readback", csrOut, 8'h60 | c);
      n = 0;
      while (cntOut == 8'h20 && n < 5000) begin
        @(negedge clk);
        n++;
      end
      check("R2", $sformatf("period cks=%0d", c), n, 1 << shTab[c]);
      check("R2", "first step", cntOut, 8'h21);
    end

    // R3 overflow without reset enable
    wr(SRC, KEY, 8'h00);
    arm(8'h61, 8'hFD);
    watch(600, oh, ph, mh, pr, mr);
    check("R3", "ovf width", oh, 128);
    check("R8", "no reset por", ph, 0);
    check("R8", "no reset mres", mh, 0);
    check("R3", "flag set", rcsrOut, 8'h80);
    check("R8", "csr kept", csrOut, 8'h61);
    wr(SCSR, KEY, 8'h00);

    // R9 flag clear rules
    wr(SRC, KEY, 8'h80); check("R9", "write 1 keeps", rcsrOut, 8'h80);
    wr(SRC, KEY, 8'h00); check("R9", "write 0 clears", rcsrOut, 8'h00);
    wr(SRC, KEY, 8'h80); check("R9", "write 1 no set", rcsrOut, 8'h00);

    // R12 second overflow inside the pulse
    arm(8'h60, 8'hFE);
    waitOvf();
    n = 1;
    wr(SCNT, KEY, 8'hFF);
    n += 2;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!ovfOut) break;
      n++;
    end
    check("R12", "pulse not restarted", n, 128);
    check("R12", "second wrap seen", int'(cntOut < 8'h80), 1);
    wr(SCSR, KEY, 8'h00);

    // R4 / R5 power-on type
    wr(SRC, KEY, 8'h40);
    arm(8'h61, 8'hFD);
    watch(600, oh, ph, mh, pr, mr);
    check("R4", "por at rise", pr, 1);
    check("R5", "mres at rise", mr, 0);
    check("R3", "ovf width", oh, 128);
    check("R4", "por width", ph, 512);
    check("R5", "mres idle", mh, 0);
    check("R8", "cnt cleared", cntOut, 0);
    check("R8", "csr cleared", csrOut, 0);
    check("R7", "rcsr kept", rcsrOut, 8'hC0);

    // R5 manual type
    wr(SRC, KEY, 8'h60);
    arm(8'h61, 8'hFD);
    watch(600, oh, ph, mh, pr, mr);
    check("R5", "mres at rise", mr, 1);
    check("R4", "mres width", mh, 512);
    check("R5", "por idle", ph, 0);
    check("R7", "rcsr kept", rcsrOut, 8'hE0);

    // R6 manual-reset pin beats overflow reset
    wr(SRC, KEY, 8'hC0);
    check("R9", "flag kept", rcsrOut, 8'hC0);
    mresN = 1'b0;
    arm(8'h61, 8'hFD);
    watch(600, oh, ph, mh, pr, mr);
    check("R6", "ovf still", oh, 128);
    check("R6", "no por", ph, 0);
    check("R6", "no mres", mh, 0);
    check("R6", "flag cleared", rcsrOut, 8'h40);
    check("R8", "pin keeps csr", csrOut, 8'h61);
    mresN = 1'b1;
    wr(SCSR, KEY, 8'h00);
    wr(SCNT, KEY, 8'h37);
    mresN = 1'b0;
    repeat (4) @(negedge clk);
    check("R8", "pin keeps cnt", cntOut, 8'h37);
    mresN = 1'b1;

    // R7 / R13 power-on clears the reset-control register
    porN = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", "rcsr cleared", rcsrOut, 0);
    check("R13", "cnt cleared", cntOut, 0);
    porN = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule